// File: doc/BRIEF.md
# Quarter-Rate Quadrature IF Combiner

This block places a complex baseband stream onto a real intermediate-frequency carrier running at exactly one quarter of the output sample rate. For example, a 24 kHz carrier at 96,000 samples per second gives four samples per carrier period. At that ratio the cosine and sine of the carrier phase only take the values 1, 0 and -1. Each output sample is therefore one of I, Q, -I or -Q, and no multiplier or sine table is needed. A 2-bit phase register picks which term is used. The output alternates between the in-phase term and the quadrature term, and every second I/Q pair is negated.

Samples enter through a valid/ready handshake, one signed I/Q pair per output sample. A pair is taken on any rising clock edge where both `in_valid` and `in_ready` are high. The output side has no back-pressure, so `in_ready` stays high whenever the block is out of reset. An upstream source may stall by holding `in_valid` low. The phase does not move during a stall, so the carrier sequence resumes where it stopped. The output is a single registered real stream qualified by a one-cycle `out_valid` strobe. Negating the most-negative two's-complement value saturates to the largest positive value.

Top module: `qif_combiner`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0, `out_data` is 0 and `in_ready` is 0.
- R2: From the first rising edge after `rst_n` goes high, `in_ready` is 1 and stays 1 for as long as `rst_n` stays high.
- R3: Accepted pairs are numbered k = 0, 1, 2, … from reset. Pair k produces I when k mod 4 = 0, Q when k mod 4 = 1, -I when k mod 4 = 2 and -Q when k mod 4 = 3.
- R4: `out_valid` is high in the cycle after each accepted pair and low in every other cycle. `out_data` carries that pair's result while `out_valid` is high.
- R5: A cycle with `in_valid` low does not advance the phase, and `out_data` keeps its last value. Data presented on `in_i`/`in_q` in such a cycle has no effect.
- R6: Negating the most-negative value -2^(DATA_W-1) gives 2^(DATA_W-1)-1. Every other value is negated exactly.
- R7: Asserting reset in the middle of a stream returns the phase to 0, so the first pair accepted after reset produces I.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pair valid |
| in_ready | output | 1 | Block can accept a pair |
| in_i | input | DATA_W | In-phase sample, signed two's complement |
| in_q | input | DATA_W | Quadrature sample, signed two's complement |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | DATA_W | Real IF sample, signed two's complement |

## Verification
With the width set to 4 bits, every one of the 256 I/Q pairs is presented at every carrier phase. This separates a swapped I/Q selection, a wrong negation phase and a missing saturation, because the pairs that contain -8 are the only ones that expose the clamp. One sweep puts idle cycles carrying junk data between samples. That shows that stalls neither advance the phase nor disturb the held output, which a back-to-back stream cannot reveal. A reset in mid-stream then shows that the phase restarts at the I term.

// File: rtl/qif_pkg.sv
package qif_pkg;
  typedef enum logic [1:0] {
    PH_I_POS = 2'd0,
    PH_Q_POS = 2'd1,
    PH_I_NEG = 2'd2,
    PH_Q_NEG = 2'd3
  } qif_phase_e;
endpackage

// File: rtl/qif_phase_ctr.sv
module qif_phase_ctr
  import qif_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  output qif_phase_e phase
);
  always_ff @(posedge clk) begin
    if (!rst_n)   phase <= PH_I_POS;
    else if (adv) phase <= qif_phase_e'(phase + 2'd1);
  end
endmodule

// File: rtl/qif_sat_neg.sv
module qif_sat_neg #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] a,
  output logic signed [W-1:0] y
);
  localparam logic signed [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};
  always_comb y = (a == MOST_NEG) ? MOST_POS : -a;
endmodule

// File: rtl/qif_term_sel.sv
module qif_term_sel
  import qif_pkg::*;
#(
  parameter int W = 16
) (
  input  qif_phase_e          phase,
  input  logic signed [W-1:0] i_s,
  input  logic signed [W-1:0] q_s,
  output logic signed [W-1:0] term
);
  localparam int NCH = 2;
  logic signed [W-1:0] src [NCH];
  logic signed [W-1:0] neg [NCH];

  assign src[0] = i_s;
  assign src[1] = q_s;

  for (genvar c = 0; c < NCH; c++) begin : g_neg
    qif_sat_neg #(.W(W)) u_neg (.a(src[c]), .y(neg[c]));
  end

  always_comb begin
    unique case (phase)
      PH_I_POS: term = src[0];
      PH_Q_POS: term = src[1];
      PH_I_NEG: term = neg[0];
      PH_Q_NEG: term = neg[1];
      default:  term = src[0];
    endcase
  end
endmodule

// File: rtl/qif_out_reg.sv
module qif_out_reg #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic signed [W-1:0] d,
  output logic                vld,
  output logic signed [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= 1'b0;
      q   <= '0;
    end else begin
      vld <= load;
      if (load) q <= d;
    end
  end
endmodule

// File: rtl/qif_combiner.sv
module qif_combiner
  import qif_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_i,
  input  logic signed [DATA_W-1:0] in_q,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_data
);
  qif_phase_e                phase_q;
  logic signed [DATA_W-1:0]  term;
  logic                      accept;

  always_ff @(posedge clk) begin
    if (!rst_n) in_ready <= 1'b0;
    else        in_ready <= 1'b1;
  end

  assign accept = in_valid & in_ready;

  qif_phase_ctr u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (accept),
    .phase (phase_q)
  );

  qif_term_sel #(.W(DATA_W)) u_sel (
    .phase (phase_q),
    .i_s   (in_i),
    .q_s   (in_q),
    .term  (term)
  );

  qif_out_reg #(.W(DATA_W)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .d     (term),
    .vld   (out_valid),
    .q     (out_data)
  );
endmodule

// File: rtl/qif_combiner_chk.sv
module qif_combiner_chk #(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic signed [W-1:0] in_i,
  input logic signed [W-1:0] in_q,
  input logic                out_valid,
  input logic signed [W-1:0] out_data,
  input logic [1:0]          phase
);
  localparam logic signed [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  logic acc;
  assign acc = in_valid && in_ready;

  // R1: outputs quiet while held in reset
  always @(posedge clk) begin
    if (!rst_n) a_r1_reset_quiet: assert (!out_valid || $past(rst_n));
  end

  a_r2_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready);

  a_r3_phase_i: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && phase == 2'd0) |=> out_data == $past(in_i));

  a_r3_phase_q: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && phase == 2'd1) |=> out_data == $past(in_q));

  a_r3_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && phase == 2'd3) |=> phase == 2'd0);

  a_r4_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !out_valid);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(phase) && $stable(out_data)));

  a_r6_sat_i: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && phase == 2'd2 && in_i == MOST_NEG) |=> out_data == MOST_POS);

  a_r6_sat_q: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && phase == 2'd3 && in_q == MOST_NEG) |=> out_data == MOST_POS);
endmodule

bind qif_combiner qif_combiner_chk #(.W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_i      (in_i),
  .in_q      (in_q),
  .out_valid (out_valid),
  .out_data  (out_data),
  .phase     (phase_q)
);

// File: tb/tb_qif_combiner.sv
`timescale 1ns/1ps
module tb_qif_combiner;
  localparam int W    = 4;
  localparam int VMIN = -(1 << (W-1));
  localparam int VMAX = (1 << (W-1)) - 1;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                in_valid = 1'b0;
  logic                in_ready;
  logic signed [W-1:0] in_i = '0;
  logic signed [W-1:0] in_q = '0;
  logic                out_valid;
  logic signed [W-1:0] out_data;

  int tests = 0;
  int fails = 0;
  int ph = 0;
  bit pending = 0;
  int exp_val = 0;
  int last_out = 0;

  always #4 clk = ~clk;

  qif_combiner #(.DATA_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic int neg_sat(int x);
    return (x == VMIN) ? VMAX : -x;
  endfunction

  function automatic int expect_of(int p, int a, int b);
    case (p)
      0: return a;
      1: return b;
      2: return neg_sat(a);
      default: return neg_sat(b);
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One cycle: check result of previous cycle, then drive this one.
  task automatic step(bit v, int a, int b);
    @(negedge clk);
    chk("R2 in_ready", int'(in_ready), 1);
    if (pending) begin
      chk("R4 out_valid", int'(out_valid), 1);
      chk("R3/R6 out_data", int'(out_data), exp_val);
      last_out = exp_val;
    end else begin
      chk("R4 idle out_valid", int'(out_valid), 0);
      chk("R5 hold out_data", int'(out_data), last_out);
    end
    in_valid = v;
    in_i = W'(a);
    in_q = W'(b);
    pending = v;
    if (v) begin
      exp_val = expect_of(ph, a, b);
      ph = (ph + 1) % 4;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 out_data", int'(out_data), 0);
    chk("R1 in_ready", int'(in_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 ready after reset", int'(in_ready), 1);
    pending = 0;
    ph = 0;
    last_out = 0;
  endtask

  initial begin
    do_reset();
    // Exhaustive sweeps: each sweep shifted by one phase via a leading sample
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < s; k++) step(1, 1, 2);
      for (int a = VMIN; a <= VMAX; a++)
        for (int b = VMIN; b <= VMAX; b++) begin
          step(1, a, b);
          // R5: on sweep 2 insert stalls with junk data
          if (s == 2 && ((a + b) & 1) != 0) step(0, b, a);
        end
    end
    step(0, 0, 0);
    step(0, 0, 0);
    // R7: reset in mid-stream restarts at the I term
    step(1, 3, 5);
    step(1, 3, 5);
    step(0, 0, 0);
    do_reset();
    step(1, 6, -2);
    step(0, 0, 0);
    // R6 explicit corner: most-negative I at phase 2
    step(1, 1, 1);
    step(1, VMIN, 0);
    step(0, 0, 0);
    step(0, 0, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule